// File: doc/BRIEF.md
# ATA PIO Cycle Timing Engine

This block is the host side of a parallel ATA bus for programmed I/O. Software stores a direction, a 4-bit device register index and a write word in a small register set, then writes the start bit. The engine runs one 16-bit bus cycle. It drives the chip selects and the three address lines, pulses the read or the write strobe, and either captures the device's data or holds its own data on the bus. When the cycle ends it raises a done bit in an interrupt status register.

Every phase of the cycle is counted in clocks from programmed timing words. The address setup time and the write-data hold time are shared by all cycles. The strobe width and the recovery time come from one of two sets. Cycles to the data port at index 0 use the data set. Cycles to every other index use the register set. A device that is not ready can stretch the strobe through IORDY when software enables this. One control bit drives the bus reset line.

Top module: `ata_pio_engine`

## Requirements
- R1: After reset, both strobes, both chip selects and the reset line are high, the data bus is not driven, the status register (offset 7) reads 0 and the mask register (offset 8) reads 1.
- R2: Writing offset 0 with bit 0 set starts a cycle. Bit 1 selects direction: 1 is a write, 0 is a read. In the clock after the start write, the chip selects and the address are driven with both strobes high. This setup phase lasts max(t1,1) clocks, where t1 is bits 3:0 of offset 5.
- R3: The strobe stays low for max(w,1) clocks. For the data port (index 0), w is bits 7:0 of offset 6. For any other index, w is bits 15:8 of offset 4.
- R4: After the strobe rises, the chip selects stay asserted for a recovery of max(t2,1) clocks. For the data port, t2 is bits 11:4 of offset 5. For any other index, t2 is bits 7:0 of offset 4. On a write, recovery is lengthened to max(t4,1) clocks when that is longer, where t4 is bits 15:12 of offset 5.
- R5: On a write, only the write strobe pulses. The word from offset 2 is driven with output enable high from the first setup clock until max(t4,1) clocks after the strobe rises, and no longer.
- R6: On a read, only the read strobe pulses. The bus value present in the last strobe-low clock is readable at offset 3 once the cycle is done.
- R7: Status bit 1 is set in the first clock after the chip selects release. Writing 1 to a status bit clears it. Offset 0 bit 0 reads 1 only while a cycle runs.
- R8: A start written while a cycle runs is ignored. That cycle keeps its address, direction and single strobe, and no second cycle follows.
- R9: With offset 0 bit 2 set, a low IORDY held at the end of the strobe width extends the strobe until the first clock edge that samples IORDY high. With bit 2 clear, IORDY has no effect.
- R10: Status bit 0 latches a high device interrupt input. The interrupt output is the OR of the status bits that are also set in the mask.
- R11: Offset 0 bit 3 drives the bus reset line low from the clock after it is written as 1 until the clock after it is written as 0.
- R12: Index bit 3 selects the chip select: 0 selects chip select 0, 1 selects chip select 1. Index bits 2:0 drive the address lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset for writes and reads |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for cfg_addr, combinational |
| irq | output | 1 | Masked interrupt request |
| ata_reset_n | output | 1 | Bus reset line, active low |
| ata_cs0_n | output | 1 | Chip select 0, active low |
| ata_cs1_n | output | 1 | Chip select 1, active low |
| ata_da | output | 3 | Bus address lines |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_out | output | 16 | Data driven to the bus |
| ata_dd_oe | output | 1 | Output enable for ata_dd_out |
| ata_dd_in | input | 16 | Data from the bus |
| ata_iordy | input | 1 | Device ready, already synchronous to clk |
| ata_intrq | input | 1 | Device interrupt, already synchronous to clk |

## Verification
The start write is sampled on a rising edge, and the setup phase is visible in the clock that follows. The length of every later phase is counted from there. The done bit and the captured read word become readable in the first clock after the chip selects release. Changes to the reset line and the interrupt status appear one clock after the register write or the input level. The bench samples every output on the falling edge and counts the clocks of each phase against max(value,1) arithmetic. It checks the done bit in the exact clock where it is due. For IORDY, it releases the line in a chosen clock and expects the strobe to end in that same clock.

// File: rtl/ata_pio_pkg.sv
// Package: shared types, widths and register offsets of the ATA PIO engine.
// Assumes a 16-bit register interface and 16-bit bus data.
package ata_pio_pkg;

    // width of the long phase counts (strobe width, recovery)
    localparam int TIM_W   = 8;
    // width of the short phase counts (setup, write hold)
    localparam int SHORT_W = 4;

    // register offsets of the software interface
    localparam logic [3:0] OFS_CTRL  = 4'd0;
    localparam logic [3:0] OFS_DADDR = 4'd1;
    localparam logic [3:0] OFS_TXD   = 4'd2;
    localparam logic [3:0] OFS_RXD   = 4'd3;
    localparam logic [3:0] OFS_RTIM  = 4'd4;
    localparam logic [3:0] OFS_DTIM0 = 4'd5;
    localparam logic [3:0] OFS_DTIM1 = 4'd6;
    localparam logic [3:0] OFS_STAT  = 4'd7;
    localparam logic [3:0] OFS_MASK  = 4'd8;

    // control bit positions
    localparam int CB_START = 0;
    localparam int CB_WRITE = 1;
    localparam int CB_IORDY = 2;
    localparam int CB_DRST  = 3;

    // status bit positions
    localparam int SB_DEV  = 0;
    localparam int SB_DONE = 1;
    localparam int N_STAT  = 2;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_RECOV  = 2'd3
    } phase_e;

    // clock counts for one bus cycle, already chosen for its register class
    typedef struct packed {
        logic [TIM_W-1:0] setup;
        logic [TIM_W-1:0] active;
        logic [TIM_W-1:0] recov;
        logic [TIM_W-1:0] hold;
    } cyc_tim_t;

endpackage

// File: rtl/ata_pio_tsel.sv
// Module: picks the timing set for a cycle from the device register index.
// Index DATA_IDX selects the data-cycle set; every other index selects the
// register-cycle set. Setup and hold always come from the data timing word.
module ata_pio_tsel
    import ata_pio_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 4,
    parameter int DATA_IDX = 0
) (
    input  logic [ADDR_W-1:0] dev_addr_i,
    input  logic [DATA_W-1:0] reg_tim_i,
    input  logic [DATA_W-1:0] dat_tim0_i,
    input  logic [DATA_W-1:0] dat_tim1_i,
    output cyc_tim_t          tim_o
);
    localparam int REC_LSB  = SHORT_W;
    localparam int HOLD_LSB = SHORT_W + TIM_W;
    localparam int HOLD_W   = DATA_W - HOLD_LSB;

    logic is_data;

    // classify the access and assemble the per-phase counts
    always_comb begin
        is_data      = (dev_addr_i == ADDR_W'(DATA_IDX));
        tim_o.setup  = TIM_W'(dat_tim0_i[SHORT_W-1:0]);
        tim_o.hold   = TIM_W'(dat_tim0_i[DATA_W-1 -: HOLD_W]);
        tim_o.active = is_data ? dat_tim1_i[TIM_W-1:0] : reg_tim_i[2*TIM_W-1:TIM_W];
        tim_o.recov  = is_data ? dat_tim0_i[REC_LSB +: TIM_W] : reg_tim_i[TIM_W-1:0];
    end
endmodule

// File: rtl/ata_pio_regs.sv
// Module: software register set of the PIO engine: control, address, data,
// timing words, write-1-to-clear status and interrupt mask.
// Assumes one register access per clock; reads are combinational.
module ata_pio_regs
    import ata_pio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    parameter int REG_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] rx_i,
    input  logic              intrq_i,
    output logic              start_o,
    output logic              launch_wr_o,
    output logic              launch_ien_o,
    output logic              dev_rst_o,
    output logic [ADDR_W-1:0] dev_addr_o,
    output logic [DATA_W-1:0] tx_o,
    output logic [DATA_W-1:0] reg_tim_o,
    output logic [DATA_W-1:0] dat_tim0_o,
    output logic [DATA_W-1:0] dat_tim1_o,
    output logic              irq_o
);
    logic              dir_q, ien_q, drst_q;
    logic [N_STAT-1:0] stat_q, mask_q, stat_set;
    logic              wr_ctrl, wr_stat;

    // decode of the writes that feed more than one process
    always_comb begin
        wr_ctrl      = cfg_wr && (cfg_addr == REG_AW'(OFS_CTRL));
        wr_stat      = cfg_wr && (cfg_addr == REG_AW'(OFS_STAT));
        start_o      = wr_ctrl && cfg_wdata[CB_START];
        launch_wr_o  = wr_ctrl ? cfg_wdata[CB_WRITE] : dir_q;
        launch_ien_o = wr_ctrl ? cfg_wdata[CB_IORDY] : ien_q;
        dev_rst_o    = drst_q;
        stat_set     = '0;
        stat_set[SB_DEV]  = intrq_i;
        stat_set[SB_DONE] = done_i;
        irq_o        = |(stat_q & mask_q);
    end

    // control bits that persist between starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            ien_q  <= 1'b0;
            drst_q <= 1'b0;
        end else if (wr_ctrl) begin
            dir_q  <= cfg_wdata[CB_WRITE];
            ien_q  <= cfg_wdata[CB_IORDY];
            drst_q <= cfg_wdata[CB_DRST];
        end
    end

    // address, transmit word and timing words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_addr_o <= '0;
            tx_o       <= '0;
            reg_tim_o  <= '0;
            dat_tim0_o <= '0;
            dat_tim1_o <= '0;
        end else if (cfg_wr) begin
            case (cfg_addr)
                REG_AW'(OFS_DADDR): dev_addr_o <= cfg_wdata[ADDR_W-1:0];
                REG_AW'(OFS_TXD):   tx_o       <= cfg_wdata;
                REG_AW'(OFS_RTIM):  reg_tim_o  <= cfg_wdata;
                REG_AW'(OFS_DTIM0): dat_tim0_o <= cfg_wdata;
                REG_AW'(OFS_DTIM1): dat_tim1_o <= cfg_wdata;
                default: ;
            endcase
        end
    end

    // status bits: events set, write-1 clears, a set wins over a clear
    generate
        for (genvar i = 0; i < N_STAT; i++) begin : g_stat
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stat_q[i] <= 1'b0;
                else if (stat_set[i])
                    stat_q[i] <= 1'b1;
                else if (wr_stat && cfg_wdata[i])
                    stat_q[i] <= 1'b0;
            end
        end
    endgenerate

    // interrupt mask, device interrupt enabled out of reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= N_STAT'(1);
        else if (cfg_wr && (cfg_addr == REG_AW'(OFS_MASK)))
            mask_q <= cfg_wdata[N_STAT-1:0];
    end

    // read-back multiplexer
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            REG_AW'(OFS_CTRL): begin
                cfg_rdata[CB_START] = busy_i;
                cfg_rdata[CB_WRITE] = dir_q;
                cfg_rdata[CB_IORDY] = ien_q;
                cfg_rdata[CB_DRST]  = drst_q;
            end
            REG_AW'(OFS_DADDR): cfg_rdata = DATA_W'(dev_addr_o);
            REG_AW'(OFS_TXD):   cfg_rdata = tx_o;
            REG_AW'(OFS_RXD):   cfg_rdata = rx_i;
            REG_AW'(OFS_RTIM):  cfg_rdata = reg_tim_o;
            REG_AW'(OFS_DTIM0): cfg_rdata = dat_tim0_o;
            REG_AW'(OFS_DTIM1): cfg_rdata = dat_tim1_o;
            REG_AW'(OFS_STAT):  cfg_rdata = DATA_W'(stat_q);
            REG_AW'(OFS_MASK):  cfg_rdata = DATA_W'(mask_q);
            default: ;
        endcase
    end

    // R7: a finished cycle is visible in status on the next clock
    a_r7_done_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> stat_q[SB_DONE]);
    // R7: write-1 clears the done bit when no new completion arrives
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && cfg_wdata[SB_DONE] && !done_i) |=> !stat_q[SB_DONE]);
    // R10: a high device interrupt is latched
    a_r10_dev_latch: assert property (@(posedge clk) disable iff (!rst_n)
        intrq_i |=> stat_q[SB_DEV]);
endmodule

// File: rtl/ata_pio_seq.sv
// Module: phase sequencer for one PIO bus cycle (setup, strobe, recovery).
// Latches address, direction, data and timing at launch. A count of zero is
// treated as one clock. IORDY is assumed synchronous to clk.
module ata_pio_seq
    import ata_pio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              wr_i,
    input  logic              ien_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  cyc_tim_t          tim_i,
    input  logic              iordy_i,
    input  logic [DATA_W-1:0] din_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              cs0_n_o,
    output logic              cs1_n_o,
    output logic [ADDR_W-2:0] da_o,
    output logic              dior_n_o,
    output logic              diow_n_o,
    output logic [DATA_W-1:0] dout_o,
    output logic              doe_o
);
    phase_e            phase_q;
    logic [TIM_W-1:0]  elapsed_q;
    cyc_tim_t          tim_q;
    logic              wr_q, ien_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wd_q, rx_q;

    logic [TIM_W-1:0]  setup_len, act_len, rec_len, hold_len, wrec_len, ph_len;
    logic              ph_last, stall, advance, launch, cap;

    function automatic logic [TIM_W-1:0] at_least_one(input logic [TIM_W-1:0] v);
        return (v == '0) ? TIM_W'(1) : v;
    endfunction

    // phase length, end-of-phase and IORDY stall decisions
    always_comb begin
        setup_len = at_least_one(tim_q.setup);
        act_len   = at_least_one(tim_q.active);
        rec_len   = at_least_one(tim_q.recov);
        hold_len  = at_least_one(tim_q.hold);
        wrec_len  = (hold_len > rec_len) ? hold_len : rec_len;
        case (phase_q)
            PH_SETUP:  ph_len = setup_len;
            PH_ACTIVE: ph_len = act_len;
            PH_RECOV:  ph_len = wr_q ? wrec_len : rec_len;
            default:   ph_len = TIM_W'(1);
        endcase
        ph_last = (elapsed_q == ph_len - TIM_W'(1));
        stall   = (phase_q == PH_ACTIVE) && ien_q && !iordy_i;
        advance = (phase_q != PH_IDLE) && ph_last && !stall;
        launch  = start_i && (phase_q == PH_IDLE);
        cap     = (phase_q == PH_ACTIVE) && advance && !wr_q;
        done_o  = (phase_q == PH_RECOV) && advance;
        busy_o  = (phase_q != PH_IDLE);
    end

    // phase state and in-phase clock counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            elapsed_q <= '0;
        end else if (launch) begin
            phase_q   <= PH_SETUP;
            elapsed_q <= '0;
        end else if (advance) begin
            elapsed_q <= '0;
            case (phase_q)
                PH_SETUP:  phase_q <= PH_ACTIVE;
                PH_ACTIVE: phase_q <= PH_RECOV;
                default:   phase_q <= PH_IDLE;
            endcase
        end else if (busy_o && !ph_last) begin
            elapsed_q <= elapsed_q + TIM_W'(1);
        end
    end

    // launch-time copy of the cycle parameters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim_q  <= '0;
            wr_q   <= 1'b0;
            ien_q  <= 1'b0;
            addr_q <= '0;
            wd_q   <= '0;
        end else if (launch) begin
            tim_q  <= tim_i;
            wr_q   <= wr_i;
            ien_q  <= ien_i;
            addr_q <= addr_i;
            wd_q   <= wdata_i;
        end
    end

    // read capture in the last strobe-low clock
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_q <= '0;
        else if (cap)
            rx_q <= din_i;
    end

    // bus pins from the phase state
    always_comb begin
        cs0_n_o  = !(busy_o && !addr_q[ADDR_W-1]);
        cs1_n_o  = !(busy_o &&  addr_q[ADDR_W-1]);
        da_o     = busy_o ? addr_q[ADDR_W-2:0] : '0;
        dior_n_o = !((phase_q == PH_ACTIVE) && !wr_q);
        diow_n_o = !((phase_q == PH_ACTIVE) &&  wr_q);
        dout_o   = wd_q;
        doe_o    = wr_q && ((phase_q == PH_SETUP) || (phase_q == PH_ACTIVE) ||
                            ((phase_q == PH_RECOV) && (elapsed_q < hold_len)));
        rdata_o  = rx_q;
    end

    // R8: a start during a cycle leaves the latched cycle untouched
    a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(addr_q) && $stable(wr_q) && $stable(wd_q)));
    // R9: a low IORDY with waits enabled keeps the strobe phase
    a_r9_iordy_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_ACTIVE && ien_q && !iordy_i) |=> (phase_q == PH_ACTIVE));
    // R6: the captured word is the bus value of the final strobe clock
    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (rdata_o == $past(din_i)));
    // R5: write data still drives in the clock the write strobe rises
    a_r5_hold_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(diow_n_o) |-> doe_o);
endmodule

// File: rtl/ata_pio_engine.sv
// Module: top of the ATA PIO cycle engine. Joins the register set, the
// timing-set selector and the phase sequencer, and drives the bus reset.
// Assumes ata_iordy and ata_intrq are already synchronous to clk.
module ata_pio_engine
    import ata_pio_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 4,
    parameter int REG_AW   = 4,
    parameter int DATA_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              irq,
    output logic              ata_reset_n,
    output logic              ata_cs0_n,
    output logic              ata_cs1_n,
    output logic [ADDR_W-2:0] ata_da,
    output logic              ata_dior_n,
    output logic              ata_diow_n,
    output logic [DATA_W-1:0] ata_dd_out,
    output logic              ata_dd_oe,
    input  logic [DATA_W-1:0] ata_dd_in,
    input  logic              ata_iordy,
    input  logic              ata_intrq
);
    logic              busy, done, start, launch_wr, launch_ien, dev_rst;
    logic [ADDR_W-1:0] dev_addr;
    logic [DATA_W-1:0] tx, rx, reg_tim, dat_tim0, dat_tim1;
    cyc_tim_t          tim_sel;

    ata_pio_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_AW(REG_AW)) i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .busy_i       (busy),
        .done_i       (done),
        .rx_i         (rx),
        .intrq_i      (ata_intrq),
        .start_o      (start),
        .launch_wr_o  (launch_wr),
        .launch_ien_o (launch_ien),
        .dev_rst_o    (dev_rst),
        .dev_addr_o   (dev_addr),
        .tx_o         (tx),
        .reg_tim_o    (reg_tim),
        .dat_tim0_o   (dat_tim0),
        .dat_tim1_o   (dat_tim1),
        .irq_o        (irq)
    );

    ata_pio_tsel #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DATA_IDX(DATA_IDX)) i_tsel (
        .dev_addr_i (dev_addr),
        .reg_tim_i  (reg_tim),
        .dat_tim0_i (dat_tim0),
        .dat_tim1_i (dat_tim1),
        .tim_o      (tim_sel)
    );

    ata_pio_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .wr_i     (launch_wr),
        .ien_i    (launch_ien),
        .addr_i   (dev_addr),
        .wdata_i  (tx),
        .tim_i    (tim_sel),
        .iordy_i  (ata_iordy),
        .din_i    (ata_dd_in),
        .busy_o   (busy),
        .done_o   (done),
        .rdata_o  (rx),
        .cs0_n_o  (ata_cs0_n),
        .cs1_n_o  (ata_cs1_n),
        .da_o     (ata_da),
        .dior_n_o (ata_dior_n),
        .diow_n_o (ata_diow_n),
        .dout_o   (ata_dd_out),
        .doe_o    (ata_dd_oe)
    );

    // bus reset line follows the control bit
    always_comb ata_reset_n = !dev_rst;

    // R11: writing the reset bit pulls the bus reset line low next clock
    a_r11_reset_line: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == REG_AW'(OFS_CTRL) && cfg_wdata[CB_DRST]) |=> !ata_reset_n);
    // R2: a strobe is only ever low while a chip select is asserted
    a_r2_strobe_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
        (!ata_dior_n || !ata_diow_n) |-> (!ata_cs0_n || !ata_cs1_n));
endmodule

// File: tb/test_ata_pio_engine.sv
module test_ata_pio_engine;
    localparam logic [3:0] A_CTRL = 4'd0, A_DADDR = 4'd1, A_TXD = 4'd2, A_RXD = 4'd3,
                           A_RTIM = 4'd4, A_DTIM0 = 4'd5, A_DTIM1 = 4'd6,
                           A_STAT = 4'd7, A_MASK = 4'd8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_addr = 4'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [15:0] cfg_rdata;
    logic        irq, ata_reset_n, ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_dd_oe;
    logic [2:0]  ata_da;
    logic [15:0] ata_dd_out, ata_dd_in;
    logic        ata_iordy = 1'b1;
    logic        ata_intrq = 1'b0;
    logic [15:0] rd_word = 16'h0;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    // simple device responder: drives a word only while the read strobe is low
    assign ata_dd_in = !ata_dior_n ? rd_word : 16'h0000;

    ata_pio_engine i_ata_pio_engine (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
        .ata_reset_n(ata_reset_n), .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n),
        .ata_da(ata_da), .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n),
        .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe), .ata_dd_in(ata_dd_in),
        .ata_iordy(ata_iordy), .ata_intrq(ata_intrq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    function automatic int cl1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // one bus cycle, measured clock by clock at the falling edge
    task automatic xfer(input bit wr, input logic [3:0] da, input logic [15:0] wd,
                        input bit ien, input int rel_c, input bit inject,
                        input int e_set, input int e_act, input int e_rec, input int e_oe);
        int s = 0, a = 0, r = 0, oe_after = 0, bad_str = 0, bad_cs = 0, bad_d = 0;
        int done_bit = 0, idle_cs = 0;
        bit seen = 1'b0, ended = 1'b0;
        reg_write(A_DADDR, {12'h0, da});
        reg_write(A_TXD, wd);
        rd_word = wd ^ 16'h5A3C;
        ata_iordy = (rel_c != 0) ? 1'b0 : 1'b1;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = A_CTRL; cfg_wdata = {12'h0, 1'b0, ien, wr, 1'b1};
        @(negedge clk);
        cfg_wr = 1'b0; cfg_addr = A_STAT;
        for (int c = 1; c < 400 && !ended; c++) begin
            if (!ata_cs0_n || !ata_cs1_n) begin
                if (ata_cs0_n != da[3] || ata_cs1_n != !da[3] || ata_da != da[2:0]) bad_cs++;
                if (!ata_dior_n || !ata_diow_n) begin
                    a++; seen = 1'b1;
                    if (wr ? !ata_dior_n : !ata_diow_n) bad_str++;
                    if (wr && (!ata_dd_oe || ata_dd_out != wd)) bad_d++;
                end else if (!seen) begin
                    s++;
                    if (wr && !ata_dd_oe) bad_d++;
                end else begin
                    r++;
                    if (ata_dd_oe) oe_after++;
                end
            end else begin
                done_bit = int'(cfg_rdata[1]);
                ended = 1'b1;
            end
            if (inject && c == 2) begin
                cfg_wr = 1'b1; cfg_addr = A_CTRL; cfg_wdata = {12'h0, 1'b0, ien, !wr, 1'b1};
            end
            if (inject && c == 3) begin
                cfg_wr = 1'b0; cfg_addr = A_STAT;
            end
            if (c == rel_c) ata_iordy = 1'b1;
            if (!ended) @(negedge clk);
        end
        ata_iordy = 1'b1;
        chk("R2 setup clocks", s, e_set);
        chk("R3 strobe clocks", a, e_act);
        chk("R4 recovery clocks", r, e_rec);
        chk("R5 hold clocks", oe_after, e_oe);
        chk(wr ? "R5 strobe kind" : "R6 strobe kind", bad_str, 0);
        chk("R12 select and address", bad_cs, 0);
        if (wr) chk("R5 write data", bad_d, 0);
        chk("R7 done in first idle clock", done_bit, 1);
        if (!wr) begin
            cfg_addr = A_RXD; #1;
            chk("R6 read word", int'(cfg_rdata), int'(rd_word));
        end
        cfg_addr = A_CTRL; #1;
        chk("R7 start reads clear", int'(cfg_rdata[0]), 0);
        reg_write(A_STAT, 16'h0002);
        cfg_addr = A_STAT; #1;
        chk("R7 write-1 clear", int'(cfg_rdata[1]), 0);
        if (inject) begin
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (!ata_cs0_n || !ata_cs1_n) idle_cs++;
            end
            chk("R8 no second cycle", idle_cs, 0);
        end
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int t1v[3] = '{0, 1, 3};
        int acv[3] = '{0, 1, 4};
        int rcv[3] = '{0, 2, 5};
        int hdv[3] = '{0, 3, 7};
        logic [3:0] rix[4] = '{4'h1, 4'h7, 4'h8, 4'hE};
        int idx = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 dior", int'(ata_dior_n), 1);
        chk("R1 diow", int'(ata_diow_n), 1);
        chk("R1 selects", int'({ata_cs0_n, ata_cs1_n}), 3);
        chk("R1 reset line", int'(ata_reset_n), 1);
        chk("R1 bus enable", int'(ata_dd_oe), 0);
        chk("R1 irq", int'(irq), 0);
        cfg_addr = A_STAT; #1;
        chk("R1 status", int'(cfg_rdata), 0);
        cfg_addr = A_MASK; #1;
        chk("R1 mask", int'(cfg_rdata), 1);

        // near-exhaustive sweep of phase counts, both directions, both timing sets
        foreach (t1v[i1]) foreach (acv[i2]) foreach (rcv[i3]) foreach (hdv[i4]) begin
            int t1 = t1v[i1], ac = acv[i2], rc = rcv[i3], hd = hdv[i4];
            reg_write(A_RTIM, {8'(ac + 1), 8'(rc + 2)});
            reg_write(A_DTIM0, {4'(hd), 8'(rc), 4'(t1)});
            reg_write(A_DTIM1, {8'h0, 8'(ac)});
            for (int w = 0; w < 2; w++) begin
                int rec;
                // data port, index 0
                rec = (w == 1 && cl1(hd) > cl1(rc)) ? cl1(hd) : cl1(rc);
                xfer(w[0], 4'h0, 16'(16'h1234 + idx * 7), 1'b0, 0, 1'b0,
                     cl1(t1), cl1(ac), rec, (w == 1) ? cl1(hd) : 0);
                // register port, other indices
                rec = (w == 1 && cl1(hd) > rc + 2) ? cl1(hd) : rc + 2;
                xfer(w[0], rix[idx % 4], 16'(16'hBEEF - idx * 3), 1'b0, 0, 1'b0,
                     cl1(t1), ac + 1, rec, (w == 1) ? cl1(hd) : 0);
                idx++;
            end
        end

        // R9: IORDY extension, early release, and disabled waits
        reg_write(A_RTIM, {8'd3, 8'd2});
        reg_write(A_DTIM0, {4'd1, 8'd2, 4'd2});
        reg_write(A_DTIM1, 16'd3);
        xfer(1'b0, 4'h0, 16'hA5A5, 1'b1, 2 + 3 + 2, 1'b0, 2, 5, 2, 0); // R9 stretched read
        xfer(1'b1, 4'h3, 16'h0F0F, 1'b1, 2 + 3 + 4, 1'b0, 2, 7, 2, 1); // R9 stretched write
        xfer(1'b0, 4'h0, 16'h1111, 1'b1, 1, 1'b0, 2, 3, 2, 0);         // R9 early release
        xfer(1'b0, 4'h9, 16'h2222, 1'b0, 300, 1'b0, 2, 3, 2, 0);       // R9 disabled, IORDY low

        // R8: start while busy
        xfer(1'b1, 4'h0, 16'hC0DE, 1'b0, 0, 1'b1, 2, 3, 2, 1);
        xfer(1'b0, 4'hA, 16'h7777, 1'b0, 0, 1'b1, 2, 3, 2, 0);

        // R10: device interrupt latch and masking
        @(negedge clk); ata_intrq = 1'b1;
        @(negedge clk); ata_intrq = 1'b0;
        cfg_addr = A_STAT; #1;
        chk("R10 device bit latched", int'(cfg_rdata[0]), 1);
        chk("R10 irq with mask 1", int'(irq), 1);
        reg_write(A_MASK, 16'h0000);
        chk("R10 irq masked", int'(irq), 0);
        reg_write(A_STAT, 16'h0001);
        cfg_addr = A_STAT; #1;
        chk("R10 device bit cleared", int'(cfg_rdata[0]), 0);
        reg_write(A_MASK, 16'h0002);
        reg_write(A_DADDR, 16'h0005);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = A_CTRL; cfg_wdata = 16'h0001;
        @(negedge clk);
        cfg_wr = 1'b0;
        repeat (15) @(negedge clk);
        chk("R10 irq from done", int'(irq), 1);
        reg_write(A_STAT, 16'h0002);
        chk("R10 irq after clear", int'(irq), 0);
        reg_write(A_MASK, 16'h0001);

        // R11: bus reset line
        reg_write(A_CTRL, 16'h0008);
        chk("R11 reset asserted", int'(ata_reset_n), 0);
        chk("R11 no cycle from reset bit", int'(ata_cs0_n & ata_cs1_n), 1);
        reg_write(A_CTRL, 16'h0000);
        chk("R11 reset released", int'(ata_reset_n), 1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule